// File: doc/BRIEF.md
# Serial Receive Data Register with Interrupt

This block is the register-facing receive side of a serial port. Each byte delivered by the bit-level receiver, one `rx_valid` pulse per byte, goes into a one-entry holding slot and raises a receive-not-empty flag. Software reads the byte through a data register. A read of that register hands back the held byte and clears the flag. The same data offset, when written, passes a byte to the transmit path as a one-cycle strobe.

An interrupt request line is high while the slot holds an unread byte and the receive interrupt enable in control register 1 is set. An interrupt controller takes the line as interrupt number 37. Transmission is treated as instant, so the transmit-empty flag always reads as 1. No transmit-empty interrupt is generated, because that flag would keep the request asserted forever.

The slot is run by a three-state machine held in `state_q`. `SLOT_EMPTY` means no unread byte. `SLOT_FULL` means one unread byte. `SLOT_OVERRUN` means one unread byte that replaced an earlier unread one. The transitions are:

- LOAD: from empty to full, when a byte arrives.
- DRAIN: from full or overrun to empty, when the data register is read with no byte arriving.
- OVERWRITE: from full or overrun to overrun, when a byte arrives with no read.
- REFILL: from any state to full, when a byte arrives in the same cycle as a data read.
- HOLD: stay in the current state, when there is neither a byte nor a read.

Top module: `serial_rx_regs`

## Requirements
- R1: After reset the status register (offset 0x00) reads 0x80, control register 1 (offset 0x0C) reads 0, and `irq_rx` and `tx_strobe` are low.
- R2: An `rx_valid` pulse stores `rx_data` and sets receive-not-empty (status bit 5) from the next cycle on.
- R3: A read at offset 0x04 places the held byte in `bus_rdata[7:0]` (upper bits 0) one cycle after the request. At the same clock edge it clears receive-not-empty and the overrun flag.
- R4: Reads of the status register and of control register 1 change no flag.
- R5: A write at offset 0x04 drives `tx_strobe` high for exactly the next cycle, with `tx_data` equal to `bus_wdata[7:0]`. The receive slot is left unchanged.
- R6: The transmit-empty flag (status bit 7) reads 1 at all times.
- R7: Control register 1 is 32 bits and reads back what was written. `irq_rx` is high exactly while receive-not-empty and control register 1 bit 5 are both 1.
- R8: A byte that arrives while receive-not-empty is set, with no data read in that cycle, replaces the held byte and sets the overrun flag (status bit 3).
- R9: When a byte arrives in the same cycle as a data read, the read returns the old byte. The new byte is then held, receive-not-empty stays set and the overrun flag is 0.
- R10: Writes to the status register or to an unmapped offset have no effect, and reads of an unmapped offset return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered, valid the cycle after a read |
| rx_valid | input | 1 | One-cycle pulse: a received byte is on `rx_data` |
| rx_data | input | 8 | Received byte |
| tx_strobe | output | 1 | One-cycle pulse: a byte was written for transmission |
| tx_data | output | 8 | Byte for the transmit path |
| irq_rx | output | 1 | Receive interrupt request |

## Verification
Every state change is registered once. A byte pulse or a data read drives its flag and `irq_rx` change on the very next clock edge, and read data appears on `bus_rdata` at that same edge. A data write produces `tx_strobe` at the following edge, and the strobe drops one edge later. The bench drives inputs on the falling edge and samples half a cycle after the next rising edge, so each result is checked in the first cycle in which it is due. Where a strobe must last a single cycle, the bench checks it again one cycle later.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;
    localparam int unsigned OFF_STATUS = 0;
    localparam int unsigned OFF_DATA   = 4;
    localparam int unsigned OFF_CTRL1  = 12;

    localparam int unsigned ORE_BIT    = 3;
    localparam int unsigned RXNE_BIT   = 5;
    localparam int unsigned TXE_BIT    = 7;
    localparam int unsigned RXIE_BIT   = 5;

    typedef enum logic [1:0] {
        SLOT_EMPTY   = 2'd0,
        SLOT_FULL    = 2'd1,
        SLOT_OVERRUN = 2'd2
    } slot_state_e;
endpackage

// File: rtl/srx_decode.sv
module srx_decode #(
    parameter int unsigned ADDR_W = 4
) (
    input  logic              sel,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    output logic              rd_status,
    output logic              rd_data,
    output logic              rd_ctrl1,
    output logic              wr_data,
    output logic              wr_ctrl1,
    output logic              rd_any
);
    import serial_rx_pkg::*;

    localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFF_STATUS);
    localparam logic [ADDR_W-1:0] A_DATA   = ADDR_W'(OFF_DATA);
    localparam logic [ADDR_W-1:0] A_CTRL1  = ADDR_W'(OFF_CTRL1);

    logic hit_status, hit_data, hit_ctrl1;

    always_comb begin
        hit_status = (addr == A_STATUS);
        hit_data   = (addr == A_DATA);
        hit_ctrl1  = (addr == A_CTRL1);
        rd_status  = sel && !wr && hit_status;
        rd_data    = sel && !wr && hit_data;
        rd_ctrl1   = sel && !wr && hit_ctrl1;
        wr_data    = sel &&  wr && hit_data;
        wr_ctrl1   = sel &&  wr && hit_ctrl1;
        rd_any     = sel && !wr;
    end

    // R10: at most one register strobe per access
    always_comb begin
        assert_one_strobe_R10: assert ($onehot0({rd_status, rd_data, rd_ctrl1, wr_data, wr_ctrl1}))
            else $error("more than one register strobe");
    end
endmodule

// File: rtl/srx_slot_fsm.sv
module srx_slot_fsm #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              pop,
    output logic [DATA_W-1:0] hold_q,
    output logic              rxne,
    output logic              ore
);
    import serial_rx_pkg::*;

    slot_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SLOT_EMPTY;
        else        state_q <= state_d;
    end

    // next state: LOAD, DRAIN, OVERWRITE, REFILL, HOLD
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SLOT_EMPTY: begin
                if (rx_valid) state_d = SLOT_FULL;           // LOAD
            end
            SLOT_FULL, SLOT_OVERRUN: begin
                if (rx_valid && pop)  state_d = SLOT_FULL;     // REFILL
                else if (rx_valid)    state_d = SLOT_OVERRUN;  // OVERWRITE
                else if (pop)         state_d = SLOT_EMPTY;    // DRAIN
            end
            default: state_d = SLOT_EMPTY;
        endcase
    end

    // outputs decoded from state
    always_comb begin
        rxne = 1'b0;
        ore  = 1'b0;
        unique case (state_q)
            SLOT_EMPTY:   begin rxne = 1'b0; ore = 1'b0; end
            SLOT_FULL:    begin rxne = 1'b1; ore = 1'b0; end
            SLOT_OVERRUN: begin rxne = 1'b1; ore = 1'b1; end
            default:      begin rxne = 1'b0; ore = 1'b0; end
        endcase
    end

    // holding register: newest byte always wins
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        hold_q <= '0;
        else if (rx_valid) hold_q <= rx_data;
    end

    assert_rx_sets_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> (rxne && hold_q == $past(rx_data)))
        else $error("byte not captured");

    assert_pop_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !rx_valid) |=> (!rxne && !ore))
        else $error("data read did not clear flags");

    assert_overrun_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rxne && !pop) |=> ore)
        else $error("overrun not flagged");

    assert_refill_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && pop) |=> (rxne && !ore))
        else $error("simultaneous read and arrival mishandled");

    assert_idle_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_valid && !pop) |=> ($stable(rxne) && $stable(ore)))
        else $error("flags changed without cause");
endmodule

// File: rtl/srx_ctrl1.sv
module srx_ctrl1 #(
    parameter int unsigned REG_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] ctrl_q,
    output logic             rx_ie
);
    import serial_rx_pkg::*;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     ctrl_q <= '0;
        else if (wr_en) ctrl_q <= wdata;
    end

    always_comb rx_ie = ctrl_q[RXIE_BIT];

    assert_ctrl_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (ctrl_q == $past(wdata)))
        else $error("control register write lost");

    assert_ctrl_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(ctrl_q))
        else $error("control register changed without write");
endmodule

// File: rtl/srx_tx_gen.sv
module srx_tx_gen #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic              tx_strobe,
    output logic [DATA_W-1:0] tx_data
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_strobe <= 1'b0;
            tx_data   <= '0;
        end else begin
            tx_strobe <= wr_en;
            if (wr_en) tx_data <= wdata;
        end
    end

    assert_tx_follows_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (tx_strobe && tx_data == $past(wdata)))
        else $error("write did not reach transmit path");

    assert_tx_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_strobe && !wr_en) |=> !tx_strobe)
        else $error("transmit strobe longer than one cycle");
endmodule

// File: rtl/serial_rx_regs.sv
module serial_rx_regs #(
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned REG_W  = 32,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    output logic              tx_strobe,
    output logic [DATA_W-1:0] tx_data,
    output logic              irq_rx
);
    import serial_rx_pkg::*;

    logic rd_status, rd_data, rd_ctrl1, wr_data, wr_ctrl1, rd_any;
    logic [DATA_W-1:0] hold_q;
    logic rxne, ore, rx_ie;
    logic [REG_W-1:0] ctrl_q;
    logic [REG_W-1:0] status_word, rd_mux;

    srx_decode #(.ADDR_W(ADDR_W)) u_decode (
        .sel(bus_sel), .wr(bus_wr), .addr(bus_addr),
        .rd_status(rd_status), .rd_data(rd_data), .rd_ctrl1(rd_ctrl1),
        .wr_data(wr_data), .wr_ctrl1(wr_ctrl1), .rd_any(rd_any)
    );

    srx_slot_fsm #(.DATA_W(DATA_W)) u_slot (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
        .pop(rd_data), .hold_q(hold_q), .rxne(rxne), .ore(ore)
    );

    srx_ctrl1 #(.REG_W(REG_W)) u_ctrl1 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_ctrl1), .wdata(bus_wdata),
        .ctrl_q(ctrl_q), .rx_ie(rx_ie)
    );

    srx_tx_gen #(.DATA_W(DATA_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_data), .wdata(bus_wdata[DATA_W-1:0]),
        .tx_strobe(tx_strobe), .tx_data(tx_data)
    );

    always_comb begin
        status_word           = '0;
        status_word[TXE_BIT]  = 1'b1;
        status_word[RXNE_BIT] = rxne;
        status_word[ORE_BIT]  = ore;
    end

    always_comb begin
        rd_mux = '0;
        if (rd_status)     rd_mux = status_word;
        else if (rd_data)  rd_mux = REG_W'(hold_q);
        else if (rd_ctrl1) rd_mux = ctrl_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (rd_any) bus_rdata <= rd_mux;
    end

    always_comb irq_rx = rxne && rx_ie;

    assert_irq_raise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_ie && !wr_ctrl1) |=> irq_rx)
        else $error("interrupt not raised");

    assert_irq_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data && !rx_valid) |=> !irq_rx)
        else $error("interrupt not dropped after read");

    assert_data_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data |=> (bus_rdata == REG_W'($past(hold_q))))
        else $error("data read returned wrong byte");
endmodule

// File: tb/tb_serial_rx_regs.sv
module tb_serial_rx_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        tx_strobe;
    logic [7:0]  tx_data;
    logic        irq_rx;

    int checks = 0, errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    serial_rx_regs dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rx_valid(rx_valid), .rx_data(rx_data), .tx_strobe(tx_strobe),
        .tx_data(tx_data), .irq_rx(irq_rx)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
        d = bus_rdata;
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic push_byte(input logic [7:0] b);
        @(negedge clk);
        rx_valid = 1'b1; rx_data = b;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk("R1 irq", {31'd0, irq_rx}, 32'd0);
        chk("R1 tx_strobe", {31'd0, tx_strobe}, 32'd0);
        bus_read(4'h0, d); chk("R1 status", d, 32'h80);
        bus_read(4'hC, d); chk("R1 ctrl1", d, 32'h0);
    endtask

    task automatic t_receive_read();
        logic [31:0] d;
        push_byte(8'h5A);
        bus_read(4'h0, d); chk("R2 rxne set", d, 32'hA0);
        bus_read(4'h0, d); chk("R4 status read no side effect", d, 32'hA0);
        bus_read(4'hC, d); chk("R4 ctrl1 read", d, 32'h0);
        bus_read(4'h4, d); chk("R3 data byte", d, 32'h5A);
        bus_read(4'h0, d); chk("R3 rxne cleared", d, 32'h80);
        chk("R6 txe high", {31'd0, d[7]}, 32'd1);
    endtask

    task automatic t_tx_write();
        logic [31:0] d;
        push_byte(8'h11);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 4'h4; bus_wdata = 32'hFFFF_FFC3;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        chk("R5 strobe high", {31'd0, tx_strobe}, 32'd1);
        chk("R5 tx byte", {24'd0, tx_data}, 32'hC3);
        @(negedge clk);
        chk("R5 strobe one cycle", {31'd0, tx_strobe}, 32'd0);
        bus_read(4'h0, d); chk("R5 slot untouched status", d, 32'hA0);
        bus_read(4'h4, d); chk("R5 slot untouched data", d, 32'h11);
    endtask

    task automatic t_irq();
        logic [31:0] d;
        push_byte(8'h22);
        chk("R7 irq gated off", {31'd0, irq_rx}, 32'd0);
        bus_write(4'hC, 32'hDEAD_0020);
        chk("R7 irq on when enabled", {31'd0, irq_rx}, 32'd1);
        bus_read(4'hC, d); chk("R7 ctrl1 readback", d, 32'hDEAD_0020);
        bus_read(4'h4, d); chk("R7 data", d, 32'h22);
        chk("R7 irq drops after read", {31'd0, irq_rx}, 32'd0);
        push_byte(8'h23);
        chk("R7 irq on arrival", {31'd0, irq_rx}, 32'd1);
        bus_write(4'hC, 32'h0);
        chk("R7 irq off when disabled", {31'd0, irq_rx}, 32'd0);
        bus_read(4'h4, d);
    endtask

    task automatic t_overrun();
        logic [31:0] d;
        push_byte(8'hA1);
        push_byte(8'hB2);
        bus_read(4'h0, d); chk("R8 overrun flag", d, 32'hA8);
        bus_read(4'h4, d); chk("R8 newest byte", d, 32'hB2);
        bus_read(4'h0, d); chk("R3 flags cleared after overrun", d, 32'h80);
    endtask

    task automatic t_simultaneous();
        logic [31:0] d;
        push_byte(8'h31);
        push_byte(8'h32);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 4'h4;
        rx_valid = 1'b1; rx_data = 8'h33;
        @(negedge clk);
        bus_sel = 1'b0; rx_valid = 1'b0;
        chk("R9 old byte returned", bus_rdata, 32'h32);
        bus_read(4'h0, d); chk("R9 rxne kept, no overrun", d, 32'hA0);
        bus_read(4'h4, d); chk("R9 new byte held", d, 32'h33);
    endtask

    task automatic t_ignored();
        logic [31:0] d;
        bus_write(4'h0, 32'hFFFF_FFFF);
        bus_read(4'h0, d); chk("R10 status write ignored", d, 32'h80);
        bus_write(4'h8, 32'h0000_0020);
        chk("R10 unmapped write no tx", {31'd0, tx_strobe}, 32'd0);
        bus_read(4'hC, d); chk("R10 ctrl1 untouched", d, 32'h0);
        bus_read(4'h8, d); chk("R10 unmapped read zero", d, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_receive_read();
        t_tx_write();
        t_irq();
        t_overrun();
        t_simultaneous();
        t_ignored();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule